// File: doc/BRIEF.md
# Pulse-Swallow Feedback Divider

This block divides a fast input clock by a programmable integer ratio N = B·P + A and emits one single-cycle pulse per N input cycles, intended for the feedback input of a phase detector. A dual-modulus prescaler divides by either P or P+1. A swallow counter holds the prescaler in its P+1 mode for the first A prescaler cycles of each output period. A main counter ends the period after B prescaler cycles in total. Because of this split, the full ratio never needs one wide counter running at the input rate.

The base modulus P is chosen by a two-bit select input. The A, B and P values are captured only when a period ends, or continuously while the block is held. A period that is in progress therefore always finishes with the values it started with. A synchronous counter-reset input and a power-down input each park the counters in their load state. A ratio-valid output reports whether the captured settings give a legal, gap-free ratio.

Top module: `pulse_swallow_div`

## Requirements
- R1: With A ≤ B and B ≥ 1, consecutive `div_out` pulses are exactly N = B·P + A input clock cycles apart.
- R2: `psc_sel` selects the base modulus: code 0 gives P = 8, code 1 gives P = 16, and codes 2 and 3 both give P = 32.
- R3: Each `div_out` pulse is high for exactly one input clock cycle.
- R4: After `rst_n` is released, the first `div_out` pulse is seen in the cycle after the N-th rising clock edge.
- R5: A change to `psc_sel`, `swallow_a` or `main_b` in the middle of a period leaves that period's length unchanged. The new values set the length of the following period.
- R6: While `cnt_rst` is high, `div_out` stays low and the counters sit in their load state using the live input values. The first pulse after release comes N cycles later, as in R4.
- R7: `pwr_dn` behaves like `cnt_rst`: no pulses while it is high, and the first pulse comes N cycles after release.
- R8: `ratio_ok` is high exactly when the captured settings satisfy A ≤ B and N ≥ P² − P, which implies B ≥ 3. It follows the captured values one cycle after capture. Boundary examples: with P = 8, B = 7 and A = 0 (N = 56) it is high, and with B = 6 and A = 6 (N = 54) it is low.
- R9: When A > B, `ratio_ok` is low and the period becomes B·(P+1) cycles.
- R10: While `rst_n` is low, `div_out` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock to be divided |
| rst_n | input | 1 | Synchronous active-low reset |
| psc_sel | input | 2 | Prescaler base modulus select (0: 8, 1: 16, 2 or 3: 32) |
| swallow_a | input | A_W | Swallow count A |
| main_b | input | B_W | Main count B |
| cnt_rst | input | 1 | Holds the counters in their load state while high |
| pwr_dn | input | 1 | Power-down; parks the counters in their load state while high |
| div_out | output | 1 | One-cycle pulse per N input cycles |
| ratio_ok | output | 1 | High when the captured A, B, P give a legal contiguous ratio |

## Verification
The ratio is measured as the distance between pulses for each prescaler code, with A = 0, with A at its largest value, and with a mid-range A. This separates a wrong base modulus from a wrong swallow count, because A = 0 exercises only the P mode while a large A stresses the P+1 mode. A settings change made a few cycles into a period shows whether capture happens at the boundary or immediately: the first interval must keep the old length. Validity is probed on both sides of the P² − P limit and with A > B, and the A > B case is also timed to confirm it yields B·(P+1).

// File: rtl/psd_pkg.sv
// Shared definitions for the pulse-swallow divider.
// Assumes: prescaler base moduli are 8, 16 or 32 only.
package psd_pkg;

    localparam int PSC_W = 6;   // holds the largest base modulus, 32

    typedef enum logic [1:0] {
        PSC_DIV8   = 2'd0,
        PSC_DIV16  = 2'd1,
        PSC_DIV32  = 2'd2,
        PSC_DIV32X = 2'd3
    } psc_code_e;

    // Map a select code to the prescaler base modulus P.
    function automatic logic [PSC_W-1:0] psc_base(input logic [1:0] code);
        case (psc_code_e'(code))
            PSC_DIV8:  psc_base = PSC_W'(8);
            PSC_DIV16: psc_base = PSC_W'(16);
            default:   psc_base = PSC_W'(32);
        endcase
    endfunction

endpackage

// File: rtl/psd_prescaler.sv
// Dual-modulus prescaler: counts input cycles and raises tick on the last
// cycle of each prescaler cycle. The cycle length is base+1 when plus_one
// is set at the moment of (re)load, otherwise base.
// Assumes: base >= 2 and stable between reloads.
module psd_prescaler #(
    parameter int PSC_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reload,
    input  logic [PSC_W-1:0] base,
    input  logic             plus_one,
    output logic             tick
);

    logic [PSC_W-1:0] cnt;

    assign tick = (cnt == '0);

    // Count down; restart at base (P+1 states) or base-1 (P states).
    always_ff @(posedge clk) begin
        if (!rst_n || reload || tick) begin
            cnt <= plus_one ? base : base - PSC_W'(1);
        end else begin
            cnt <= cnt - PSC_W'(1);
        end
    end

endmodule

// File: rtl/psd_swallow_ctrl.sv
// Swallow and main counters with the period-boundary settings capture.
// Drives the prescaler modulus: P+1 while swallow cycles remain, else P.
// Assumes: tick comes from the prescaler driven by base/plus_one below.
module psd_swallow_ctrl
    import psd_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold,
    input  logic             tick,
    input  logic [1:0]       psel_in,
    input  logic [A_W-1:0]   a_in,
    input  logic [B_W-1:0]   b_in,
    output logic [PSC_W-1:0] base,
    output logic             plus_one,
    output logic             reload,
    output logic             period_end,
    output logic [1:0]       act_psel,
    output logic [A_W-1:0]   act_a,
    output logic [B_W-1:0]   act_b
);

    logic [A_W-1:0] a_rem;
    logic [B_W-1:0] b_rem;
    logic [B_W-1:0] b_load;
    logic           loading;

    assign b_load     = (b_in == '0) ? B_W'(1) : b_in;
    assign period_end = tick && (b_rem == B_W'(1)) && !hold;
    assign reload     = hold || period_end;
    assign loading    = !rst_n || reload;

    // Pick modulus source: live inputs when loading, captured values otherwise.
    always_comb begin
        if (loading) begin
            base     = psc_base(psel_in);
            plus_one = (a_in != '0);
        end else begin
            base     = psc_base(act_psel);
            plus_one = (a_rem > A_W'(1));
        end
    end

    // Capture settings at load; step both counters on every prescaler tick.
    always_ff @(posedge clk) begin
        if (loading) begin
            act_psel <= psel_in;
            act_a    <= a_in;
            act_b    <= b_in;
            a_rem    <= a_in;
            b_rem    <= b_load;
        end else if (tick) begin
            a_rem <= (a_rem != '0) ? a_rem - A_W'(1) : '0;
            b_rem <= b_rem - B_W'(1);
        end
    end

    // R5
    cfg_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loading |=> ($stable(act_a) && $stable(act_b) && $stable(act_psel)));

    // R1
    swallow_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !loading |=> (a_rem <= act_a));

    // R1
    main_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> (b_rem != '0));

endmodule

// File: rtl/psd_ratio_check.sv
// Ratio legality: A must not exceed B, and N = B*P + A must be at least
// P*P - P for the ratio to lie in the gap-free range.
// Assumes: B_W > A_W.
module psd_ratio_check
    import psd_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 13
) (
    input  logic [1:0]     psel,
    input  logic [A_W-1:0] a_val,
    input  logic [B_W-1:0] b_val,
    output logic           ok
);

    localparam int N_W = B_W + PSC_W;

    logic [PSC_W-1:0] p;
    logic [N_W-1:0]   n_ratio;
    logic [N_W-1:0]   n_min;
    logic [B_W-1:0]   a_ext;

    // Compute the ratio, its lower contiguity limit and the A<=B test.
    always_comb begin
        p       = psc_base(psel);
        a_ext   = {{(B_W-A_W){1'b0}}, a_val};
        n_ratio = N_W'(b_val) * N_W'(p) + N_W'(a_val);
        n_min   = N_W'(p) * N_W'(p) - N_W'(p);
        ok      = (a_ext <= b_val) && (n_ratio >= n_min);
    end

endmodule

// File: rtl/pulse_swallow_div.sv
// Pulse-swallow feedback divider top: prescaler, swallow/main counters,
// ratio check and the registered output pulse.
// Assumes: cnt_rst and pwr_dn are synchronous to clk.
module pulse_swallow_div
    import psd_pkg::*;
#(
    parameter int A_W = 5,
    parameter int B_W = 13
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [1:0]     psc_sel,
    input  logic [A_W-1:0] swallow_a,
    input  logic [B_W-1:0] main_b,
    input  logic           cnt_rst,
    input  logic           pwr_dn,
    output logic           div_out,
    output logic           ratio_ok
);

    logic             hold;
    logic             tick;
    logic [PSC_W-1:0] base;
    logic             plus_one;
    logic             reload;
    logic             period_end;
    logic [1:0]       act_psel;
    logic [A_W-1:0]   act_a;
    logic [B_W-1:0]   act_b;

    assign hold = cnt_rst || pwr_dn;

    psd_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .base     (base),
        .plus_one (plus_one),
        .tick     (tick)
    );

    psd_swallow_ctrl #(.A_W(A_W), .B_W(B_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (hold),
        .tick       (tick),
        .psel_in    (psc_sel),
        .a_in       (swallow_a),
        .b_in       (main_b),
        .base       (base),
        .plus_one   (plus_one),
        .reload     (reload),
        .period_end (period_end),
        .act_psel   (act_psel),
        .act_a      (act_a),
        .act_b      (act_b)
    );

    psd_ratio_check #(.A_W(A_W), .B_W(B_W)) u_chk (
        .psel  (act_psel),
        .a_val (act_a),
        .b_val (act_b),
        .ok    (ratio_ok)
    );

    // Register the end-of-period strobe as the output pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || hold) begin
            div_out <= 1'b0;
        end else begin
            div_out <= period_end;
        end
    end

    // R3
    pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_out |=> !div_out);

    // R6 / R7
    hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !div_out);

    // R10
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !div_out);

    // R8
    ratio_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ratio_ok |-> ({{(B_W-A_W){1'b0}}, act_a} <= act_b));

endmodule

// File: tb/pulse_swallow_div_bench.sv
`timescale 1ns/1ps
module pulse_swallow_div_bench;

    localparam int A_W   = 5;
    localparam int B_W   = 13;
    localparam int LIMIT = 5000;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [1:0]     psc_sel = 2'd0;
    logic [A_W-1:0] swallow_a = '0;
    logic [B_W-1:0] main_b = B_W'(10);
    logic           cnt_rst = 1'b0;
    logic           pwr_dn = 1'b0;
    logic           div_out;
    logic           ratio_ok;

    int n_tests = 0;
    int n_fail  = 0;

    always #2 clk = ~clk;

    pulse_swallow_div #(.A_W(A_W), .B_W(B_W)) u_pulse_swallow_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .psc_sel   (psc_sel),
        .swallow_a (swallow_a),
        .main_b    (main_b),
        .cnt_rst   (cnt_rst),
        .pwr_dn    (pwr_dn),
        .div_out   (div_out),
        .ratio_ok  (ratio_ok)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int code, input int a, input int b);
        psc_sel   = 2'(code);
        swallow_a = A_W'(a);
        main_b    = B_W'(b);
    endtask

    // Count negedges until a pulse is seen.
    task automatic wait_pulse(output int cyc);
        cyc = 0;
        do begin
            @(negedge clk);
            cyc++;
        end while (!div_out && cyc < LIMIT);
    endtask

    task automatic check_width(input string req);
        @(negedge clk);
        check(!div_out, req, int'(div_out), 0);
    endtask

    // R10: no pulse while in reset.
    task automatic t_reset();
        int seen = 0;
        rst_n = 1'b0;
        set_cfg(0, 3, 10);
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (div_out) seen++;
        end
        check(seen == 0, "R10", seen, 0);
    endtask

    // R4, R1, R3, R8: first pulse after reset and steady period.
    task automatic t_first_pulse();
        int cyc;
        rst_n = 1'b1;
        wait_pulse(cyc);
        check(cyc == 83, "R4", cyc, 83);
        check_width("R3");
        wait_pulse(cyc);
        check(cyc + 1 == 83, "R1", cyc + 1, 83);
        check(ratio_ok, "R8", int'(ratio_ok), 1);
    endtask

    // R1 / R2 / R9: measure the steady period for one setting.
    task automatic t_ratio(input int code, input int a, input int b,
                           input int exp, input string req);
        int cyc;
        set_cfg(code, a, b);
        wait_pulse(cyc);
        wait_pulse(cyc);
        check(cyc == exp, req, cyc, exp);
        check_width("R3");
    endtask

    // R5: mid-period change takes effect only at the next boundary.
    task automatic t_boundary();
        int cyc;
        set_cfg(0, 0, 7);
        wait_pulse(cyc);
        wait_pulse(cyc);
        repeat (5) @(negedge clk);
        set_cfg(0, 2, 12);
        wait_pulse(cyc);
        check(cyc + 5 == 56, "R5", cyc + 5, 56);
        wait_pulse(cyc);
        check(cyc == 98, "R5", cyc, 98);
    endtask

    // R6 / R7: hold blocks pulses, captures live settings, restarts cleanly.
    task automatic t_hold(input bit use_pd, input string req);
        int cyc;
        int seen = 0;
        set_cfg(0, 3, 10);
        if (use_pd) pwr_dn = 1'b1; else cnt_rst = 1'b1;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (div_out) seen++;
            if (i == 100) set_cfg(1, 1, 20);
        end
        check(seen == 0, req, seen, 0);
        pwr_dn  = 1'b0;
        cnt_rst = 1'b0;
        wait_pulse(cyc);
        check(cyc == 321, req, cyc, 321);
    endtask

    // R8 / R9: ratio_ok on both sides of the limits.
    task automatic t_valid(input int code, input int a, input int b,
                           input bit exp, input string req);
        cnt_rst = 1'b1;
        set_cfg(code, a, b);
        repeat (2) @(negedge clk);
        check(ratio_ok == exp, req, int'(ratio_ok), int'(exp));
    endtask

    initial begin
        t_reset();
        t_first_pulse();
        t_ratio(1, 0, 20, 320, "R2");
        t_ratio(2, 31, 33, 1087, "R2");
        t_ratio(3, 5, 40, 1285, "R2");
        t_ratio(0, 0, 7, 56, "R1");
        t_ratio(0, 4, 9, 76, "R1");
        t_boundary();
        t_hold(1'b0, "R6");
        t_hold(1'b1, "R7");
        t_valid(0, 0, 7, 1'b1, "R8");
        t_valid(0, 6, 6, 1'b0, "R8");
        t_valid(1, 0, 15, 1'b1, "R8");
        t_valid(1, 14, 14, 1'b0, "R8");
        t_valid(2, 0, 31, 1'b1, "R8");
        t_valid(2, 30, 30, 1'b0, "R8");
        t_valid(0, 11, 10, 1'b0, "R9");
        cnt_rst = 1'b0;
        t_ratio(0, 11, 10, 90, "R9");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule